// File: doc/BRIEF.md
# SD Host Reset and Event Controller

This block owns the reset machinery and the event register of an SD/MMC host controller. Software reaches it through a small word-wide register port. It can request a whole-module soft reset, a controller-wide "reset all", or a reset of just the command-line state machine or just the data-line state machine. Each reset drives a level output toward the command and data paths for as long as it lasts. Each reset also clears itself, so software only writes the request and polls for completion.

The command and data paths report what happened by pulsing bits of a 32-bit event vector. The block latches these bits into a write-one-to-clear event register. Bit 15 of that register reads as a summary of all error bits. A command timeout or a data-side error marks the affected path as inhibited and starts the matching line reset by itself. The inhibit flag drops when that reset completes.

Two state machines carry the behaviour:
- **Line-reset machine** (one copy per line):
  - `LR_IDLE` goes to `LR_ACTIVE` on a start request.
  - `LR_ACTIVE` returns to `LR_IDLE` after a fixed count (completion), or at once when a controller reset aborts it.
- **Controller machine**:
  - `CR_IDLE` goes to `CR_MODULE` on a module soft-reset request, or to `CR_ALL` on a reset-all request. The module request has priority.
  - `CR_MODULE` and `CR_ALL` each return to `CR_IDLE` after a fixed count.

Top module: `sdhc_rst_ctrl`

## Requirements
- R1: After `rst_n` is released, address 3 (events) reads 0 and address 2 (control) reads 0. Address 1 (reset status) reads 1: bit 0 is reset-done, bit 1 is command inhibit, bit 2 is data inhibit. All reset outputs are low.
- R2: Writing 1 to bit 25 of address 2 starts a command-line reset. For the next LINE_RST_CYCLES (4) cycles, bit 25 reads 1 and `cmd_line_rst` is high. Then both return to 0 without software action. `dat_line_rst` stays low throughout.
- R3: Writing 1 to bit 26 of address 2 does the same for the data line, on `dat_line_rst`. The command line is not touched.
- R4: A second write of 1 to a line-reset bit while that reset is running is ignored. The reset still ends LINE_RST_CYCLES cycles after it started.
- R5: A 1 on any bit of `ev_set` sets that bit of the event register (address 3). Writing to address 3 clears exactly the bits written as 1. Writing all ones leaves the register reading 0. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: Bit 15 of address 3 is not storage. It reads as the OR of bits 16 to 31. Neither `ev_set[15]` nor a write can make it 1 on its own.
- R7: A command timeout event (bit 16) sets the command inhibit (`cmd_inhibit`, address 1 bit 1) and starts a command-line reset in the same cycle. The inhibit clears when that reset completes. The event bit stays set until software clears it.
- R8: Any of data timeout (bit 20), data CRC error (bit 21) or data end-bit error (bit 22) does the same on the data side: `dat_inhibit` is set and a data-line reset runs. The event bits remain set.
- R9: Writing 1 to bit 1 of address 0 starts a module soft reset lasting CTRL_RST_CYCLES (8) cycles. During it, reset-done (address 1 bit 0) reads 0, and `ctrl_rst`, `cmd_line_rst` and `dat_line_rst` are high. Afterwards the event register reads 0 and reset-done reads 1.
- R10: Writing 1 to bit 24 of address 2 starts a reset-all lasting CTRL_RST_CYCLES cycles. Bit 24 reads 1 while it runs and 0 afterwards. It clears the event register, and reset-done stays 1 throughout.
- R11: While a module reset or reset-all runs, register writes and `ev_set` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 config, 1 reset status, 2 control, 3 events) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_set | input | 32 | Event-set pulses from the command and data paths |
| ctrl_rst | output | 1 | High during a module reset or reset-all |
| cmd_line_rst | output | 1 | Reset level to the command-line state machine |
| dat_line_rst | output | 1 | Reset level to the data-line state machine |
| cmd_inhibit | output | 1 | Command path stalled by an error until its line reset completes |
| dat_inhibit | output | 1 | Data path stalled by an error until its line reset completes |

## Verification
The bench counts the exact length of each self-clearing pulse, cycle by cycle. A counter that is off by one would show a bit reading 1 for three or five cycles instead of four. It rewrites a running line-reset bit; a design that restarted the count would stretch the reset. It also collides an event set with a clear of the same bit; a design giving the clear priority would lose the event. It drives writes and event pulses into a running controller reset; a design that let them through would leave residue once the reset ends. It checks that error-triggered resets release the inhibit flag but keep the error bit visible, which catches a design that wipes the status on a line reset.

// File: rtl/sdhc_rst_pkg.sv
package sdhc_rst_pkg;

    localparam int REG_W = 32;

    // Register word addresses.
    localparam logic [1:0] A_CFG    = 2'd0;
    localparam logic [1:0] A_RSTAT  = 2'd1;
    localparam logic [1:0] A_SYSCTL = 2'd2;
    localparam logic [1:0] A_EVENT  = 2'd3;

    // Bit positions.
    localparam int CFG_SOFTRST   = 1;
    localparam int RSTAT_DONE    = 0;
    localparam int RSTAT_CMD_INH = 1;
    localparam int RSTAT_DAT_INH = 2;
    localparam int CTL_ALL       = 24;
    localparam int CTL_CMD       = 25;
    localparam int CTL_DAT       = 26;
    localparam int EV_SUMMARY    = 15;
    localparam int EV_ERR_LO     = 16;

    // Error events that recover through a line reset.
    localparam logic [REG_W-1:0] CMD_ERR_MASK = 32'h0001_0000;
    localparam logic [REG_W-1:0] DAT_ERR_MASK = 32'h0070_0000;

    typedef enum logic {
        LR_IDLE,
        LR_ACTIVE
    } line_state_t;

    typedef enum logic [1:0] {
        CR_IDLE,
        CR_MODULE,
        CR_ALL
    } ctrl_state_t;

endpackage

// File: rtl/sdhc_line_rst.sv
module sdhc_line_rst
    import sdhc_rst_pkg::*;
#(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic err_set,
    output logic active,
    output logic done,
    output logic inhibit
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    line_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LR_IDLE: begin
                if (start && !abort) begin
                    state_d = LR_ACTIVE;
                    cnt_d   = '0;
                end
            end
            LR_ACTIVE: begin
                if (abort || cnt_q == LAST) begin
                    state_d = LR_IDLE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        active = (state_q == LR_ACTIVE);
        done   = active && !abort && (cnt_q == LAST);
    end

    // Inhibit flag: completion or abort wins over a new error.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inhibit <= 1'b0;
        end else if (abort || done) begin
            inhibit <= 1'b0;
        end else if (err_set) begin
            inhibit <= 1'b1;
        end
    end

endmodule

// File: rtl/sdhc_ctrl_rst.sv
module sdhc_ctrl_rst
    import sdhc_rst_pkg::*;
#(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_mod,
    input  logic start_all,
    output logic busy,
    output logic mod_active,
    output logic all_active
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    ctrl_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CR_IDLE: begin
                cnt_d = '0;
                if (start_mod) begin
                    state_d = CR_MODULE;
                end else if (start_all) begin
                    state_d = CR_ALL;
                end
            end
            CR_MODULE, CR_ALL: begin
                if (cnt_q == LAST) begin
                    state_d = CR_IDLE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = CR_IDLE;
            end
        endcase
    end

    always_comb begin
        mod_active = (state_q == CR_MODULE);
        all_active = (state_q == CR_ALL);
        busy       = mod_active || all_active;
    end

endmodule

// File: rtl/sdhc_evt_reg.sv
module sdhc_evt_reg
    import sdhc_rst_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int SUM    = EV_SUMMARY,
    parameter int ERR_LO = EV_ERR_LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] ev_q,
    output logic [W-1:0] rd_val
);

    localparam logic [W-1:0] KEEP = ~(W'(1) << SUM);

    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_en ? clr_vec : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else if (flush) begin
            ev_q <= '0;
        end else begin
            ev_q <= ((ev_q & ~clr_eff) | set_vec) & KEEP;
        end
    end

    always_comb begin
        rd_val      = ev_q;
        rd_val[SUM] = |ev_q[W-1:ERR_LO];
    end

endmodule

// File: rtl/sdhc_rst_ctrl.sv
module sdhc_rst_ctrl
    import sdhc_rst_pkg::*;
#(
    parameter int LINE_RST_CYCLES = 4,
    parameter int CTRL_RST_CYCLES = 8,
    parameter bit AUTO_LINE_RST   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] ev_set,
    output logic        ctrl_rst,
    output logic        cmd_line_rst,
    output logic        dat_line_rst,
    output logic        cmd_inhibit,
    output logic        dat_inhibit
);

    localparam int NLINE = 2;

    logic        busy, mod_active, all_active;
    logic        wr_ok, mod_start, all_start, ctrl_start;
    logic [31:0] ev_gated, ev_q, ev_rd;

    logic [NLINE-1:0]  line_start, line_err, line_active, line_done, line_inh;
    logic [31:0]       line_mask [NLINE];
    int unsigned       line_bit  [NLINE];

    always_comb begin
        line_mask[0] = CMD_ERR_MASK;
        line_mask[1] = DAT_ERR_MASK;
        line_bit[0]  = CTL_CMD;
        line_bit[1]  = CTL_DAT;
    end

    // Request decode: all writes are dropped while a controller reset runs.
    always_comb begin
        wr_ok      = reg_wr && !busy;
        mod_start  = wr_ok && (reg_addr == A_CFG) && reg_wdata[CFG_SOFTRST];
        all_start  = wr_ok && (reg_addr == A_SYSCTL) && reg_wdata[CTL_ALL];
        ctrl_start = mod_start || all_start;
        ev_gated   = busy ? '0 : ev_set;
    end

    sdhc_ctrl_rst #(.CYCLES(CTRL_RST_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_mod  (mod_start),
        .start_all  (all_start),
        .busy       (busy),
        .mod_active (mod_active),
        .all_active (all_active)
    );

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        always_comb begin
            line_err[g]   = |(ev_gated & line_mask[g]);
            line_start[g] = !ctrl_start &&
                            ((wr_ok && (reg_addr == A_SYSCTL) && reg_wdata[line_bit[g]]) ||
                             (AUTO_LINE_RST && line_err[g]));
        end

        sdhc_line_rst #(.CYCLES(LINE_RST_CYCLES)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (line_start[g]),
            .abort   (busy),
            .err_set (line_err[g]),
            .active  (line_active[g]),
            .done    (line_done[g]),
            .inhibit (line_inh[g])
        );
    end

    sdhc_evt_reg u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (busy),
        .set_vec (ev_gated),
        .clr_en  (wr_ok && (reg_addr == A_EVENT)),
        .clr_vec (reg_wdata),
        .ev_q    (ev_q),
        .rd_val  (ev_rd)
    );

    // Outputs to the paths.
    always_comb begin
        ctrl_rst     = busy;
        cmd_line_rst = line_active[0] || busy;
        dat_line_rst = line_active[1] || busy;
        cmd_inhibit  = line_inh[0];
        dat_inhibit  = line_inh[1];
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG: begin
                reg_rdata = '0;
            end
            A_RSTAT: begin
                reg_rdata[RSTAT_DONE]    = !mod_active;
                reg_rdata[RSTAT_CMD_INH] = line_inh[0];
                reg_rdata[RSTAT_DAT_INH] = line_inh[1];
            end
            A_SYSCTL: begin
                reg_rdata[CTL_ALL] = all_active;
                reg_rdata[CTL_CMD] = line_active[0];
                reg_rdata[CTL_DAT] = line_active[1];
            end
            A_EVENT: begin
                reg_rdata = ev_rd;
            end
        endcase
    end

    logic unused_done;
    assign unused_done = ^line_done;

endmodule

// File: rtl/sdhc_rst_ctrl_chk.sv
module sdhc_rst_ctrl_chk
    import sdhc_rst_pkg::*;
#(
    parameter int LINE_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] ev_set,
    input logic        ctrl_rst,
    input logic        cmd_line_rst,
    input logic        dat_line_rst,
    input logic        cmd_inhibit,
    input logic        dat_inhibit,
    input logic [31:0] ev_q
);

    int unsigned cmd_run, dat_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_run <= 0;
            dat_run <= 0;
        end else begin
            cmd_run <= (cmd_line_rst && !ctrl_rst) ? cmd_run + 1 : 0;
            dat_run <= (dat_line_rst && !ctrl_rst) ? dat_run + 1 : 0;
        end
    end

    AST_CMD_LINE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_run <= LINE_CYC); // R2

    AST_DAT_LINE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        dat_run <= LINE_CYC); // R3

    AST_CMD_INH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_line_rst) |-> !cmd_inhibit); // R7

    AST_DAT_INH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_line_rst) |-> !dat_inhibit); // R8

    AST_CTRL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst |=> (ev_q == '0)); // R9

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EVENT && !ctrl_rst)
        |=> ((ev_q & $past(reg_wdata & ~ev_set)) == '0)); // R5

    AST_EVT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rst && ev_set == '0 && !(reg_wr && reg_addr == A_EVENT))
        |=> $stable(ev_q)); // R5

endmodule

bind sdhc_rst_ctrl sdhc_rst_ctrl_chk #(.LINE_CYC(LINE_RST_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .ev_set       (ev_set),
    .ctrl_rst     (ctrl_rst),
    .cmd_line_rst (cmd_line_rst),
    .dat_line_rst (dat_line_rst),
    .cmd_inhibit  (cmd_inhibit),
    .dat_inhibit  (dat_inhibit),
    .ev_q         (ev_q)
);

// File: tb/sdhc_rst_ctrl_tb.sv
module sdhc_rst_ctrl_tb;

    localparam int LINE = 4;
    localparam int CTRL = 8;
    localparam logic [1:0] AD_CFG = 2'd0, AD_RST = 2'd1, AD_CTL = 2'd2, AD_EVT = 2'd3;
    localparam logic [31:0] B_ALL = 32'h0100_0000, B_CMD = 32'h0200_0000, B_DAT = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] ev_set = '0;
    logic        ctrl_rst, cmd_line_rst, dat_line_rst, cmd_inhibit, dat_inhibit;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdhc_rst_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ev_set       (ev_set),
        .ctrl_rst     (ctrl_rst),
        .cmd_line_rst (cmd_line_rst),
        .dat_line_rst (dat_line_rst),
        .cmd_inhibit  (cmd_inhibit),
        .dat_inhibit  (dat_inhibit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; samples a register shortly after.
    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic pulse_ev(input logic [31:0] v);
        ev_set = v;
        @(negedge clk);
        ev_set = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(AD_EVT, v); chk("R1 events", v, 32'h0);
        rd(AD_CTL, v); chk("R1 control", v, 32'h0);
        rd(AD_RST, v); chk("R1 status", v, 32'h1);
        chk("R1 outputs", {27'd0, ctrl_rst, cmd_line_rst, dat_line_rst, cmd_inhibit, dat_inhibit}, 32'h0);
    endtask

    task automatic t_line(input string req, input logic [31:0] bitv);
        logic [31:0] v;
        @(negedge clk);
        wr(AD_CTL, bitv);
        for (int i = 0; i < LINE; i++) begin
            rd(AD_CTL, v); chk(req, v, bitv);
            chk(req, {30'd0, cmd_line_rst, dat_line_rst}, {30'd0, bitv == B_CMD, bitv == B_DAT});
            @(negedge clk);
        end
        rd(AD_CTL, v); chk(req, v, 32'h0);
        chk(req, {30'd0, cmd_line_rst, dat_line_rst}, 32'h0);
    endtask

    task automatic t_rewrite();
        logic [31:0] v;
        @(negedge clk);
        wr(AD_CTL, B_CMD);
        wr(AD_CTL, B_CMD);   // R4 ignored while running
        for (int i = 0; i < LINE - 1; i++) begin
            rd(AD_CTL, v); chk("R4 still running", v, B_CMD);
            @(negedge clk);
        end
        rd(AD_CTL, v); chk("R4 no restart", v, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        pulse_ev(32'h0000_0033);
        rd(AD_EVT, v); chk("R5 set", v, 32'h0000_0033);
        wr(AD_EVT, 32'h0000_0011);
        rd(AD_EVT, v); chk("R5 partial clear", v, 32'h0000_0022);
        // same-cycle set and clear of bit 0
        ev_set = 32'h1;
        wr(AD_EVT, 32'h1);
        ev_set = '0;
        rd(AD_EVT, v); chk("R5 set wins", v, 32'h0000_0023);
        wr(AD_EVT, 32'hFFFF_FFFF);
        rd(AD_EVT, v); chk("R5 all ones", v, 32'h0);
        pulse_ev(32'h0000_8000);
        rd(AD_EVT, v); chk("R6 set of summary", v, 32'h0);
        pulse_ev(32'h0002_0000);
        rd(AD_EVT, v); chk("R6 summary", v, 32'h0002_8000);
        wr(AD_EVT, 32'h0002_0000);
        rd(AD_EVT, v); chk("R6 summary drops", v, 32'h0);
    endtask

    task automatic t_err(input string req, input logic [31:0] ev, input bit cmd_side);
        logic [31:0] v;
        logic [31:0] inh;
        inh = cmd_side ? 32'h3 : 32'h5;
        pulse_ev(ev);
        for (int i = 0; i < LINE; i++) begin
            rd(AD_RST, v); chk(req, v, inh);
            chk(req, {31'd0, cmd_side ? cmd_line_rst : dat_line_rst}, 32'h1);
            @(negedge clk);
        end
        rd(AD_RST, v); chk(req, v, 32'h1);
        chk(req, {30'd0, cmd_line_rst, dat_line_rst}, 32'h0);
        rd(AD_EVT, v); chk(req, v, ev | 32'h8000);
        wr(AD_EVT, 32'hFFFF_FFFF);
    endtask

    task automatic t_mod();
        logic [31:0] v;
        pulse_ev(32'h0000_0001);
        wr(AD_CFG, 32'h2);
        for (int i = 0; i < CTRL; i++) begin
            rd(AD_RST, v); chk("R9 done low", v, 32'h0);
            chk("R9 outputs", {29'd0, ctrl_rst, cmd_line_rst, dat_line_rst}, 32'h7);
            @(negedge clk);
        end
        rd(AD_RST, v); chk("R9 done high", v, 32'h1);
        rd(AD_EVT, v); chk("R9 events cleared", v, 32'h0);
        chk("R9 ctrl_rst low", {31'd0, ctrl_rst}, 32'h0);
    endtask

    task automatic t_all();
        logic [31:0] v;
        pulse_ev(32'h0000_0010);
        wr(AD_CTL, B_ALL);
        for (int i = 0; i < CTRL; i++) begin
            rd(AD_CTL, v); chk("R10 bit set", v, B_ALL);
            rd(AD_RST, v); chk("R10 done stays", v, 32'h1);
            @(negedge clk);
        end
        rd(AD_CTL, v); chk("R10 self clear", v, 32'h0);
        rd(AD_EVT, v); chk("R10 events cleared", v, 32'h0);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(AD_CTL, B_ALL);
        pulse_ev(32'h0001_0020);
        wr(AD_CTL, B_CMD);
        wr(AD_CFG, 32'h2);
        repeat (CTRL) @(negedge clk);
        rd(AD_CTL, v); chk("R11 control idle", v, 32'h0);
        rd(AD_EVT, v); chk("R11 events", v, 32'h0);
        rd(AD_RST, v); chk("R11 status", v, 32'h1);
        chk("R11 outputs", {28'd0, ctrl_rst, cmd_line_rst, dat_line_rst, cmd_inhibit}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_line("R2 command line", B_CMD);
        t_line("R3 data line", B_DAT);
        t_rewrite();
        t_events();
        t_err("R7 command timeout", 32'h0001_0000, 1'b1);
        t_err("R8 data crc", 32'h0020_0000, 1'b0);
        t_err("R8 data timeout", 32'h0010_0000, 1'b0);
        t_mod();
        t_all();
        t_ignore();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule